// File: doc/BRIEF.md
# Addressed Serial Stream Router

This block takes a host 3-wire serial stream (load, data, clock) and routes each frame to one of three downstream 3-wire devices: two analog front-end channels and a timing generator. All three devices share one data line and one clock line. Each has its own load enable. The first three bits of a frame choose the device. The fourth bit is a write/read flag. The block consumes these four header bits and passes every later bit on unchanged, so the chosen device sees a frame that starts at its own address field.

All host inputs are asynchronous. They pass through a two-stage synchronizer into the system-clock domain, and serial clock edges are found by comparing the synchronized clock with its value one cycle earlier. While an on-chip power-up loader is busy, it takes the shared outputs through this block and the host stream is ignored. Writes steered by this block only change the live settings of the devices. The loader's default sequence is a separate input path that this block never stores or alters.

The address field means different things on different devices. For the timing generator it is four address bits, least significant first. For a front-end channel it is three address bits followed by a test bit that must stay low. The block uses this difference to guard the front-end channels against a frame with the test bit set.

Top module: `sst_router`

## Requirements
- R1: While reset is held, and right after it is released with no stimulus, all load enables, the data output and the clock output are low.
- R2: The three device-select bits are received most significant bit first. Code 0 asserts load bit 0 (front-end 1), code 1 asserts load bit 1 (front-end 2) and code 2 asserts load bit 2 (timing generator). At most one load enable is high at a time.
- R3: The four header bits never appear on the outputs. Every later host bit is forwarded in order and with its value unchanged, one output clock pulse per host clock pulse.
- R4: A frame whose fourth bit (write/read flag) is high asserts no load enable and forwards no bit.
- R5: A frame whose device-select code is 3 to 7 asserts no load enable and forwards no bit.
- R6: For a front-end target, if the fourth forwarded bit (the test bit, forwarded index 3) is high, the load enable drops before that bit's clock pulse is forwarded, and the rest of the frame is dropped, so exactly three bits arrive. For the timing-generator target the same position is an address bit and is forwarded normally.
- R7: The selected load enable is released on the same sample in which the synchronized host load is seen low. The output clock never pulses from the host path while no load enable is high.
- R8: While the loader-busy input is high, the outputs copy the loader's load, data and clock inputs with one cycle of delay, and host activity has no effect on the outputs.
- R9: If the loader becomes busy in the middle of a host frame, the rest of that frame is dropped even after busy ends. The next host frame is routed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_load_i | input | 1 | Host serial load, high for the length of a frame |
| host_data_i | input | 1 | Host serial data |
| host_sclk_i | input | 1 | Host serial clock, data taken on its rising edge |
| loader_busy_i | input | 1 | Power-up loader owns the outputs |
| loader_load_i | input | NUM_TGT | Loader load enables, one per device |
| loader_data_i | input | 1 | Loader serial data |
| loader_sclk_i | input | 1 | Loader serial clock |
| tgt_load_o | output | NUM_TGT | Device load enables (0: front-end 1, 1: front-end 2, 2: timing generator) |
| tgt_data_o | output | 1 | Shared serial data to the devices |
| tgt_sclk_o | output | 1 | Shared serial clock to the devices |

## Verification
The routing path is tried over every device-select code, both values of the write/read flag and four payload lengths and patterns. The patterns alternate the forwarded bit at index 3, so one sweep separates a front-end abort from the normal timing-generator path. The bench acts as the receiving devices. It rebuilds each delivered frame from the output clock edges and compares the chosen enable, the bit count and the bit values with values it computes from the header and payload. Separate runs sweep every loader input combination while busy, send a whole host frame while busy, and cut a host frame with busy in its header. These show that loader pass-through and host lockout behave correctly and that the block recovers on the next frame.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,  // waiting for host load
    ST_HDR  = 3'd1,  // collecting select bits and write/read flag
    ST_ARM  = 3'd2,  // target chosen, waiting for serial clock low
    ST_FWD  = 3'd3,  // forwarding bits to the chosen target
    ST_DROP = 3'd4   // discarding until host load ends
  } sst_state_e;
endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sst_fsm.sv
module sst_fsm
  import sst_pkg::*;
#(
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned NUM_TGT  = 3,
  parameter int unsigned FE_TGTS  = 2,
  parameter int unsigned TEST_IDX = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy_i,
  input  logic               s_load_i,
  input  logic               s_data_i,
  input  logic               s_sclk_i,
  output logic [NUM_TGT-1:0] fwd_load_o,
  output logic               fwd_data_o,
  output logic               fwd_sclk_o
);
  localparam int unsigned HC_W  = $clog2(SEL_W + 1);
  localparam int unsigned FC_W  = $clog2(TEST_IDX + 2);
  localparam logic [FC_W-1:0] FC_TOP = FC_W'(TEST_IDX + 1);

  sst_state_e       state_q, state_d;
  logic [SEL_W-1:0] hdr_q, hdr_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [HC_W-1:0]  hcnt_q, hcnt_d;
  logic [FC_W-1:0]  fcnt_q, fcnt_d;
  logic             sclk_q;
  logic             rise;
  logic             fwd_on;

  assign rise = s_sclk_i & ~sclk_q;

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    sel_d   = sel_q;
    hcnt_d  = hcnt_q;
    fcnt_d  = fcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (s_load_i) begin
          state_d = ST_HDR;
          hdr_d   = '0;
          hcnt_d  = '0;
        end
      end
      ST_HDR: begin
        if (!s_load_i) begin
          state_d = ST_IDLE;
        end else if (rise) begin
          if (hcnt_q == HC_W'(SEL_W)) begin
            if (!s_data_i && (hdr_q < SEL_W'(NUM_TGT))) begin
              state_d = ST_ARM;
              sel_d   = hdr_q;
            end else begin
              state_d = ST_DROP;
            end
          end else begin
            hdr_d  = {hdr_q[SEL_W-2:0], s_data_i};
            hcnt_d = hcnt_q + 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (!s_load_i) begin
          state_d = ST_IDLE;
        end else if (!s_sclk_i) begin
          state_d = ST_FWD;
          fcnt_d  = '0;
        end
      end
      ST_FWD: begin
        if (!s_load_i) begin
          state_d = ST_IDLE;
        end else if (rise) begin
          if ((sel_q < SEL_W'(FE_TGTS)) && (fcnt_q == FC_W'(TEST_IDX)) && s_data_i) begin
            state_d = ST_DROP;
          end else if (fcnt_q != FC_TOP) begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      ST_DROP: begin
        if (!s_load_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    if (busy_i) state_d = ST_DROP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      sel_q   <= '0;
      hcnt_q  <= '0;
      fcnt_q  <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      sel_q   <= sel_d;
      hcnt_q  <= hcnt_d;
      fcnt_q  <= fcnt_d;
      sclk_q  <= s_sclk_i;
    end
  end

  assign fwd_on = (state_d == ST_ARM) || (state_d == ST_FWD);

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_load
    assign fwd_load_o[i] = fwd_on && (sel_d == SEL_W'(i));
  end

  assign fwd_sclk_o = (state_d == ST_FWD) & s_sclk_i;
  assign fwd_data_o = (state_d == ST_FWD) & s_data_i;
endmodule

// File: rtl/sst_outreg.sv
module sst_outreg #(
  parameter int unsigned NUM_TGT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy_i,
  input  logic [NUM_TGT-1:0] ld_load_i,
  input  logic               ld_data_i,
  input  logic               ld_sclk_i,
  input  logic [NUM_TGT-1:0] h_load_i,
  input  logic               h_data_i,
  input  logic               h_sclk_i,
  output logic [NUM_TGT-1:0] load_o,
  output logic               data_o,
  output logic               sclk_o
);
  logic [NUM_TGT-1:0] load_d;
  logic               data_d, sclk_d;

  always_comb begin
    if (busy_i) begin
      load_d = ld_load_i;
      data_d = ld_data_i;
      sclk_d = ld_sclk_i;
    end else begin
      load_d = h_load_i;
      data_d = h_data_i;
      sclk_d = h_sclk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_o <= '0;
      data_o <= 1'b0;
      sclk_o <= 1'b0;
    end else begin
      load_o <= load_d;
      data_o <= data_d;
      sclk_o <= sclk_d;
    end
  end
endmodule

// File: rtl/sst_router.sv
module sst_router #(
  parameter int unsigned SEL_W       = 3,
  parameter int unsigned NUM_TGT     = 3,
  parameter int unsigned FE_TGTS     = 2,
  parameter int unsigned TEST_IDX    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_load_i,
  input  logic               host_data_i,
  input  logic               host_sclk_i,
  input  logic               loader_busy_i,
  input  logic [NUM_TGT-1:0] loader_load_i,
  input  logic               loader_data_i,
  input  logic               loader_sclk_i,
  output logic [NUM_TGT-1:0] tgt_load_o,
  output logic               tgt_data_o,
  output logic               tgt_sclk_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [2:0]         host_s;
  logic [NUM_TGT-1:0] h_load;
  logic               h_data, h_sclk;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  sst_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({host_load_i, host_data_i, host_sclk_i}),
    .q_o   (host_s)
  );

  sst_fsm #(
    .SEL_W(SEL_W), .NUM_TGT(NUM_TGT), .FE_TGTS(FE_TGTS), .TEST_IDX(TEST_IDX)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .busy_i     (loader_busy_i),
    .s_load_i   (host_s[2]),
    .s_data_i   (host_s[1]),
    .s_sclk_i   (host_s[0]),
    .fwd_load_o (h_load),
    .fwd_data_o (h_data),
    .fwd_sclk_o (h_sclk)
  );

  sst_outreg #(.NUM_TGT(NUM_TGT)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .busy_i    (loader_busy_i),
    .ld_load_i (loader_load_i),
    .ld_data_i (loader_data_i),
    .ld_sclk_i (loader_sclk_i),
    .h_load_i  (h_load),
    .h_data_i  (h_data),
    .h_sclk_i  (h_sclk),
    .load_o    (tgt_load_o),
    .data_o    (tgt_data_o),
    .sclk_o    (tgt_sclk_o)
  );
endmodule

// File: rtl/sst_router_chk.sv
module sst_router_chk #(
  parameter int unsigned NUM_TGT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_load_i,
  input logic               loader_busy_i,
  input logic [NUM_TGT-1:0] loader_load_i,
  input logic               loader_data_i,
  input logic               loader_sclk_i,
  input logic [NUM_TGT-1:0] tgt_load_o,
  input logic               tgt_data_o,
  input logic               tgt_sclk_o
);
  logic [2:0] age_q;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 3'd0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign settled = (age_q == 3'd7);

  // R2
  onehot_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(loader_busy_i)) |-> $onehot0(tgt_load_o));

  // R8
  loader_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && $past(loader_busy_i)) |->
      (tgt_load_o == $past(loader_load_i) && tgt_data_o == $past(loader_data_i)
       && tgt_sclk_o == $past(loader_sclk_i)));

  // R7
  sclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(loader_busy_i) && tgt_sclk_o) |-> (tgt_load_o != '0));

  // R7 (default two synchronizer stages plus one register)
  load_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !$past(loader_busy_i) && !$past(host_load_i, 3)) |-> (tgt_load_o == '0));
endmodule

bind sst_router sst_router_chk #(.NUM_TGT(NUM_TGT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_load_i   (host_load_i),
  .loader_busy_i (loader_busy_i),
  .loader_load_i (loader_load_i),
  .loader_data_i (loader_data_i),
  .loader_sclk_i (loader_sclk_i),
  .tgt_load_o    (tgt_load_o),
  .tgt_data_o    (tgt_data_o),
  .tgt_sclk_o    (tgt_sclk_o)
);

// File: tb/sst_router_bench.sv
module sst_router_bench;
  localparam int CLK_PERIOD = 25;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_load = 1'b0, host_data = 1'b0, host_sclk = 1'b0;
  logic          busy = 1'b0;
  logic [NT-1:0] ld_load = '0;
  logic          ld_data = 1'b0, ld_sclk = 1'b0;
  logic [NT-1:0] tgt_load;
  logic          tgt_data, tgt_sclk;

  int checks = 0;
  int errors = 0;

  // receiver model
  logic          rx_clr = 1'b0;
  logic [63:0]   rx_bits;
  int            rx_n;
  int            rx_stray;
  logic [NT-1:0] rx_seen;
  logic          prev_sclk;

  always #(CLK_PERIOD/2) clk = ~clk;

  sst_router u_sst_router (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_load_i   (host_load),
    .host_data_i   (host_data),
    .host_sclk_i   (host_sclk),
    .loader_busy_i (busy),
    .loader_load_i (ld_load),
    .loader_data_i (ld_data),
    .loader_sclk_i (ld_sclk),
    .tgt_load_o    (tgt_load),
    .tgt_data_o    (tgt_data),
    .tgt_sclk_o    (tgt_sclk)
  );

  always @(negedge clk) begin
    if (rx_clr) begin
      rx_bits = '0; rx_n = 0; rx_stray = 0; rx_seen = '0;
    end else begin
      rx_seen = rx_seen | tgt_load;
      if (tgt_sclk && !prev_sclk) begin
        if (tgt_load != '0) begin
          if (rx_n < 64) rx_bits[rx_n] = tgt_data;
          rx_n = rx_n + 1;
        end else begin
          rx_stray = rx_stray + 1;
        end
      end
    end
    prev_sclk = tgt_sclk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_rx();
    rx_clr = 1'b1;
    @(negedge clk);
    #1 rx_clr = 1'b0;
  endtask

  task automatic put_bit(input logic b);
    host_data = b;
    waitc(3);
    host_sclk = 1'b1;
    waitc(4);
    host_sclk = 1'b0;
    waitc(1);
  endtask

  task automatic send_frame(input logic [2:0] ds, input logic rw,
                            input logic [31:0] pay, input int nb);
    host_load = 1'b1;
    waitc(4);
    for (int i = 2; i >= 0; i--) put_bit(ds[i]);
    put_bit(rw);
    for (int i = 0; i < nb; i++) put_bit(pay[i]);
    waitc(4);
    host_load = 1'b0;
    waitc(8);
  endtask

  task automatic check_rx(input string tag, input logic [NT-1:0] exp_seen,
                          input int exp_n, input logic [31:0] pay);
    logic [63:0] mask;
    mask = (exp_n >= 64) ? '1 : ((64'd1 << exp_n) - 64'd1);
    chk(rx_seen == exp_seen, {tag, " load"}, rx_seen, exp_seen);
    chk(rx_n == exp_n, {tag, " count"}, rx_n, exp_n);
    chk((rx_bits & mask) == ({32'd0, pay} & mask), {tag, " bits"}, rx_bits & mask, {32'd0, pay} & mask);
    chk(rx_stray == 0 && tgt_load == '0 && !tgt_sclk, {tag, " idle"}, {rx_stray, 1'b0, tgt_load}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    waitc(5);
    chk(tgt_load == '0 && !tgt_data && !tgt_sclk, "R1 in reset", {tgt_load, tgt_data, tgt_sclk}, 0);
    rst_n = 1'b1;
    waitc(10);
    chk(tgt_load == '0 && !tgt_data && !tgt_sclk, "R1 after reset", {tgt_load, tgt_data, tgt_sclk}, 0);

    // R2 R3 R4 R5 R6 R7 sweep over select, flag and payload patterns
    for (int ds = 0; ds < 8; ds++) begin
      for (int rw = 0; rw < 2; rw++) begin
        for (int pat = 0; pat < 4; pat++) begin
          logic [31:0]   pay;
          int            nb, en;
          logic [NT-1:0] es;
          bit            valid;
          pay = 32'h5A3C_96E1 ^ (32'(pat) * 32'h1111_0101) ^ (32'(ds) << 5);
          pay[3] = pat[0];
          nb = 8 + pat * 4;
          valid = (rw == 0) && (ds < 3);
          es = valid ? NT'(1 << ds) : '0;
          if (!valid) en = 0;
          else if (ds < 2 && pay[3]) en = 3;  // R6 front-end test bit abort
          else en = nb;
          clear_rx();
          send_frame(3'(ds), 1'(rw), pay, nb);
          check_rx($sformatf("R2/R3/R4/R5/R6/R7 ds=%0d rw=%0d pat=%0d", ds, rw, pat), es, en, pay);
        end
      end
    end

    // R8 loader pass-through sweep
    for (int k = 0; k < 32; k++) begin
      busy = 1'b1;
      ld_load = k[2:0];
      ld_data = k[3];
      ld_sclk = k[4];
      waitc(2);
      chk(tgt_load == k[2:0] && tgt_data == k[3] && tgt_sclk == k[4], "R8 loader copy",
          {tgt_load, tgt_data, tgt_sclk}, {k[2:0], k[3], k[4]});
    end
    ld_load = '0; ld_data = 1'b0; ld_sclk = 1'b0;
    waitc(2);

    // R8 host frame ignored while busy
    clear_rx();
    send_frame(3'd2, 1'b0, 32'hFFFF_FFFF, 8);
    check_rx("R8 host while busy", '0, 0, 32'd0);
    busy = 1'b0;
    waitc(4);

    // R9 busy in mid header, frame stays dropped
    clear_rx();
    host_load = 1'b1;
    waitc(4);
    put_bit(1'b0);
    put_bit(1'b1);
    busy = 1'b1;
    waitc(6);
    busy = 1'b0;
    put_bit(1'b0);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(1'(i & 1));
    waitc(4);
    host_load = 1'b0;
    waitc(8);
    check_rx("R9 cut frame", '0, 0, 32'd0);

    // R9 next frame routed normally
    clear_rx();
    send_frame(3'd1, 1'b0, 32'h0000_00B6, 8);
    check_rx("R9 next frame", 3'b010, 8, 32'h0000_00B6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule